// File: doc/BRIEF.md
# Packed Vector Register Allocation Decoder

This block turns one compact allocation word into a full per-register configuration for a vector register file of 32 registers. The word holds one 5-bit field for each element type that the chosen base width supports. A field of zero means the type gets no registers. A nonzero field is the number of the highest register that holds that type. The type's registers start just above the previous nonzero field and run up to and including its own number. The block expands the word into a 4-bit width code and a 4-bit type code for every register. It rejects malformed words. It flags the all-zero word as "unconfigured". For every accepted word it also emits a one-cycle request to clear the predicate-register count.

The word is qualified by `cfg_valid`. The decoded arrays and flags appear, registered, one cycle later together with `out_valid`. They then hold until the next qualified word arrives. The parameter `BASE_W` (32, 64 or 128) sets the word width and the number of fields: 6, 8 or 9. A small state machine records how the last word was classified:

- `ST_IDLE`: the state after reset, before any word has been applied.
- `ST_LIVE`: the last word was legal and nonzero.
- `ST_BLANK`: the last word was all zero.
- `ST_FAULT`: the last word was rejected.

From any state, a qualified word takes the machine to `ST_FAULT` if the word is illegal, to `ST_BLANK` if it is zero, and to `ST_LIVE` otherwise. Without `cfg_valid` the machine stays where it is.

Top module: `vec_alloc_decoder`

## Requirements
- R1: Fields are taken from the least significant end, 5 bits each, in this order: 8-bit integer, 16-bit integer, 32-bit integer, 16-bit float, 32-bit float, 64-bit float. The 64-bit layout adds 64-bit integer and then 128-bit float. The 128-bit layout also adds 128-bit integer. The type codes are: int8 4'b1000, int16 4'b1001, int32 4'b1010, int64 4'b1011, int128 4'b1100, fp16 4'b0001, fp32 4'b0010, fp64 4'b0011, fp128 4'b0100. Disabled is 4'b0000. The type of register n sits at `reg_type[4n+3:4n]`.
- R2: The width code of register n sits at `reg_width[4n+3:4n]`. It is 4'b1000/1001/1010/1011/1100 for 8/16/32/64/128 bits, and 4'b0000 when the register is disabled. A float type reports the width code of its size.
- R3: A register r receives the type of the lowest-order nonzero field whose value is at least r. That field's range therefore runs from one above the previous nonzero field, or from register 0 if there is none, up to its own value inclusive.
- R4: Registers above the highest nonzero field are disabled, with width and type both 0000.
- R5: A word whose nonzero fields are not strictly increasing from low to high order sets `cfg_err`. In that case all width and type codes are 0000 and `pred_clear` stays low.
- R6: A word with any bit set above the last field (bits BASE_W-1 down to 5×fields) sets `cfg_err`, with the same outputs as R5.
- R7: An all-zero word sets `unconfigured`, clears `cfg_err` and disables every register. It is still accepted, so `pred_clear` pulses.
- R8: `pred_clear` is high for exactly the one cycle in which `out_valid` reports an accepted (non-error) word.
- R9: `out_valid` is high exactly one cycle after `cfg_valid`. The arrays, `cfg_err` and `unconfigured` are valid in that same cycle.
- R10: After reset all outputs are 0. Between qualified words the arrays and flags keep their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Qualifies `cfg_word` this cycle |
| cfg_word | input | BASE_W | Packed allocation word |
| out_valid | output | 1 | Decoded result presented this cycle |
| reg_width | output | 4×NUM_REGS | Width code per register |
| reg_type | output | 4×NUM_REGS | Type code per register |
| cfg_err | output | 1 | Last word was rejected |
| unconfigured | output | 1 | Last word was all zero |
| pred_clear | output | 1 | One-cycle request to zero the predicate count |

## Verification
A directed word with three separated fields (int32 at 1, fp32 at 12, fp64 at 18) checks range boundaries and the split between float type and width. A single field at 31 covers the full register file, and the all-zero word separates the unconfigured path from the error path. Random monotonic words exercise many different gap patterns between ranges. Random unconstrained words mostly break the ordering rule, so they tell a missed order check from correct rejection. Words with equal neighbouring fields and with padding bits set each isolate one rejection cause.

// File: rtl/vec_alloc_pkg.sv
package vec_alloc_pkg;

    localparam int FIELD_W = 5;
    localparam int CODE_W  = 4;

    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LIVE  = 2'd1,
        ST_BLANK = 2'd2,
        ST_FAULT = 2'd3
    } alloc_state_e;

    // number of type fields carried by a word of the given width
    function automatic int num_fields(input int base_w);
        if (base_w >= 128) return 9;
        if (base_w >= 64)  return 8;
        return 6;
    endfunction

    // type code owned by field position idx (least significant first)
    function automatic code_t field_type(input int idx);
        case (idx)
            0:       return 4'b1000;
            1:       return 4'b1001;
            2:       return 4'b1010;
            3:       return 4'b0001;
            4:       return 4'b0010;
            5:       return 4'b0011;
            6:       return 4'b1011;
            7:       return 4'b0100;
            8:       return 4'b1100;
            default: return 4'b0000;
        endcase
    endfunction

    // width code implied by a type code
    function automatic code_t width_of(input code_t t);
        if (t == '0) return '0;
        if (t[3])    return t;
        return t + 4'd8;
    endfunction

endpackage

// File: rtl/vec_alloc_legality.sv
module vec_alloc_legality
    import vec_alloc_pkg::*;
#(
    parameter int BASE_W = 64
) (
    input  logic [BASE_W-1:0] word,
    output logic              illegal,
    output logic              empty
);

    localparam int NF     = num_fields(BASE_W);
    localparam int USED_W = NF * FIELD_W;
    localparam int PAD_W  = BASE_W - USED_W;

    logic [FIELD_W-1:0] fld [NF];
    logic [FIELD_W-1:0] hi_seen;
    logic               any_seen;
    logic               order_bad;
    logic               pad_bad;

    for (genvar g = 0; g < NF; g++) begin : g_fld
        assign fld[g] = word[g*FIELD_W +: FIELD_W];
    end

    // nonzero fields must climb strictly from low to high order
    always_comb begin
        hi_seen   = '0;
        any_seen  = 1'b0;
        order_bad = 1'b0;
        for (int i = 0; i < NF; i++) begin
            if (fld[i] != '0) begin
                if (any_seen && (fld[i] <= hi_seen)) order_bad = 1'b1;
                hi_seen  = fld[i];
                any_seen = 1'b1;
            end
        end
    end

    if (PAD_W > 0) begin : g_pad
        assign pad_bad = |word[BASE_W-1:USED_W];
    end else begin : g_nopad
        assign pad_bad = 1'b0;
    end

    assign illegal = order_bad | pad_bad;
    assign empty   = ~|word;

endmodule

// File: rtl/vec_alloc_expand.sv
module vec_alloc_expand
    import vec_alloc_pkg::*;
#(
    parameter int BASE_W   = 64,
    parameter int NUM_REGS = 32
) (
    input  logic [num_fields(BASE_W)*FIELD_W-1:0] fields,
    output logic [CODE_W*NUM_REGS-1:0]            width_flat,
    output logic [CODE_W*NUM_REGS-1:0]            type_flat
);

    localparam int NF = num_fields(BASE_W);

    logic [FIELD_W-1:0] fld [NF];

    for (genvar g = 0; g < NF; g++) begin : g_fld
        assign fld[g] = fields[g*FIELD_W +: FIELD_W];
    end

    // per register: lowest-order nonzero field reaching this index wins
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        code_t sel_t;
        always_comb begin
            sel_t = '0;
            for (int i = NF - 1; i >= 0; i--) begin
                if ((fld[i] != '0) && (fld[i] >= FIELD_W'(r))) sel_t = field_type(i);
            end
        end
        assign type_flat [r*CODE_W +: CODE_W] = sel_t;
        assign width_flat[r*CODE_W +: CODE_W] = width_of(sel_t);
    end

endmodule

// File: rtl/vec_alloc_decoder.sv
module vec_alloc_decoder
    import vec_alloc_pkg::*;
#(
    parameter int BASE_W   = 64,
    parameter int NUM_REGS = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_valid,
    input  logic [BASE_W-1:0]          cfg_word,
    output logic                       out_valid,
    output logic [CODE_W*NUM_REGS-1:0] reg_width,
    output logic [CODE_W*NUM_REGS-1:0] reg_type,
    output logic                       cfg_err,
    output logic                       unconfigured,
    output logic                       pred_clear
);

    localparam int NF     = num_fields(BASE_W);
    localparam int USED_W = NF * FIELD_W;
    localparam int ARR_W  = CODE_W * NUM_REGS;

    alloc_state_e       state_q, state_d;
    logic               word_bad, word_empty;
    logic [ARR_W-1:0]   exp_width, exp_type;
    logic [ARR_W-1:0]   width_q, type_q;
    logic               valid_q, clear_q;

    vec_alloc_legality #(.BASE_W(BASE_W)) u_legal (
        .word    (cfg_word),
        .illegal (word_bad),
        .empty   (word_empty)
    );

    vec_alloc_expand #(.BASE_W(BASE_W), .NUM_REGS(NUM_REGS)) u_expand (
        .fields     (cfg_word[USED_W-1:0]),
        .width_flat (exp_width),
        .type_flat  (exp_type)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_LIVE, ST_BLANK, ST_FAULT: begin
                if (cfg_valid) begin
                    if (word_bad)        state_d = ST_FAULT;
                    else if (word_empty) state_d = ST_BLANK;
                    else                 state_d = ST_LIVE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered arrays and pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_q <= '0;
            type_q  <= '0;
            valid_q <= 1'b0;
            clear_q <= 1'b0;
        end else begin
            valid_q <= cfg_valid;
            clear_q <= cfg_valid & ~word_bad;
            if (cfg_valid) begin
                width_q <= word_bad ? '0 : exp_width;
                type_q  <= word_bad ? '0 : exp_type;
            end
        end
    end

    // flags decoded from state
    always_comb begin
        cfg_err      = 1'b0;
        unconfigured = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_LIVE:  ;
            ST_BLANK: unconfigured = 1'b1;
            ST_FAULT: cfg_err      = 1'b1;
            default:  ;
        endcase
    end

    assign out_valid  = valid_q;
    assign pred_clear = clear_q;
    assign reg_width  = width_q;
    assign reg_type   = type_q;

endmodule

// File: rtl/vec_alloc_decoder_chk.sv
module vec_alloc_decoder_chk #(
    parameter int NUM_REGS = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cfg_valid,
    input logic                  out_valid,
    input logic [4*NUM_REGS-1:0] reg_width,
    input logic [4*NUM_REGS-1:0] reg_type,
    input logic                  cfg_err,
    input logic                  unconfigured,
    input logic                  pred_clear
);

    // R9
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> out_valid);

    // R9
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid |=> !out_valid);

    // R8
    clear_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_clear |-> (out_valid && !cfg_err));

    // R5
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (reg_width == '0 && reg_type == '0 && !unconfigured));

    // R7
    blank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unconfigured |-> (reg_width == '0 && reg_type == '0));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid |=> ($stable(reg_width) && $stable(reg_type) &&
                        $stable(cfg_err) && $stable(unconfigured)));

endmodule

bind vec_alloc_decoder vec_alloc_decoder_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_valid    (cfg_valid),
    .out_valid    (out_valid),
    .reg_width    (reg_width),
    .reg_type     (reg_type),
    .cfg_err      (cfg_err),
    .unconfigured (unconfigured),
    .pred_clear   (pred_clear)
);

// File: tb/tb_vec_alloc_decoder.sv
module tb_vec_alloc_decoder;

    localparam int BW = 64;
    localparam int NF = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_valid = 1'b0;
    logic [BW-1:0] cfg_word = '0;
    logic          out_valid;
    logic [127:0]  reg_width, reg_type;
    logic          cfg_err, unconfigured, pred_clear;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    vec_alloc_decoder #(.BASE_W(BW), .NUM_REGS(32)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_word(cfg_word),
        .out_valid(out_valid), .reg_width(reg_width), .reg_type(reg_type),
        .cfg_err(cfg_err), .unconfigured(unconfigured), .pred_clear(pred_clear)
    );

    function automatic logic [3:0] t_code(input int i);
        logic [3:0] tab [9] = '{4'b1000, 4'b1001, 4'b1010, 4'b0001, 4'b0010,
                                4'b0011, 4'b1011, 4'b0100, 4'b1100};
        return tab[i];
    endfunction

    function automatic logic [3:0] w_code(input logic [3:0] t);
        case (t)
            4'b0001: return 4'b1001;
            4'b0010: return 4'b1010;
            4'b0011: return 4'b1011;
            4'b0100: return 4'b1100;
            default: return t;
        endcase
    endfunction

    function automatic bit is_legal(input logic [BW-1:0] w);
        int last = 0;
        if (w[BW-1:NF*5] != '0) return 1'b0;
        for (int i = 0; i < NF; i++) begin
            int v = int'(w[i*5 +: 5]);
            if (v != 0) begin
                if (v <= last) return 1'b0;
                last = v;
            end
        end
        return 1'b1;
    endfunction

    function automatic logic [127:0] exp_types(input logic [BW-1:0] w);
        logic [127:0] res = '0;
        if (!is_legal(w)) return res;
        for (int r = 0; r < 32; r++) begin
            for (int i = 0; i < NF; i++) begin
                int v = int'(w[i*5 +: 5]);
                if (v != 0 && v >= r) begin
                    res[r*4 +: 4] = t_code(i);
                    break;
                end
            end
        end
        return res;
    endfunction

    function automatic logic [127:0] exp_widths(input logic [127:0] t);
        logic [127:0] res;
        for (int r = 0; r < 32; r++) res[r*4 +: 4] = w_code(t[r*4 +: 4]);
        return res;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [BW-1:0] w, input string tag);
        logic [127:0] et, ew;
        bit legal;
        et = exp_types(w);
        ew = exp_widths(et);
        legal = is_legal(w);
        @(negedge clk);
        cfg_word  = w;
        cfg_valid = 1'b1;
        @(negedge clk);
        cfg_valid = 1'b0;
        cfg_word  = '0;
        chk(out_valid == 1'b1, "R9", {tag, " out_valid"}, 128'(out_valid), 128'(1));
        chk(reg_type == et, "R3", {tag, " types (R1 R4)"}, reg_type, et);
        chk(reg_width == ew, "R2", {tag, " widths"}, reg_width, ew);
        chk(cfg_err == !legal, "R5", {tag, " cfg_err (R6)"}, 128'(cfg_err), 128'(!legal));
        chk(unconfigured == (w == '0), "R7", {tag, " unconfigured"},
            128'(unconfigured), 128'(w == '0));
        chk(pred_clear == legal, "R8", {tag, " pred_clear"}, 128'(pred_clear), 128'(legal));
        @(negedge clk);
        chk(!out_valid && !pred_clear, "R8", {tag, " pulse ends"},
            128'({out_valid, pred_clear}), 128'(0));
        chk(reg_type == et && cfg_err == !legal, "R10", {tag, " hold"}, reg_type, et);
    endtask

    function automatic logic [BW-1:0] gen_legal();
        logic [BW-1:0] w = '0;
        int prev = 0;
        for (int i = 0; i < NF; i++) begin
            if ($urandom % 2) begin
                int v = prev + 1 + int'($urandom % 6);
                if (v <= 31) begin
                    w[i*5 +: 5] = 5'(v);
                    prev = v;
                end
            end
        end
        return w;
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [BW-1:0] w;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(!out_valid && !cfg_err && !unconfigured && !pred_clear, "R10", "reset flags",
            128'({out_valid, cfg_err, unconfigured, pred_clear}), 128'(0));
        chk(reg_width == '0 && reg_type == '0, "R10", "reset arrays", reg_type, 128'(0));

        // directed: int32 at 1, fp32 at 12, fp64 at 18 (R1 R2 R3 R4)
        w = '0; w[2*5 +: 5] = 5'd1; w[4*5 +: 5] = 5'd12; w[5*5 +: 5] = 5'd18;
        apply(w, "example");
        chk(reg_type[4*13 +: 4] == 4'b0011 && reg_width[4*13 +: 4] == 4'b1011, "R2",
            "v13 fp64", reg_width[4*13 +: 4], 128'hb);
        chk(reg_type[4*19 +: 4] == 4'b0000, "R4", "v19 disabled", reg_type[4*19 +: 4], 128'h0);
        apply({24'd0, 5'd31, 35'd0}, "fp128 full");          // R1 field 7
        apply({'0, 5'd31}, "int8 full");
        apply('0, "all zero");                              // R7
        apply({'0, 5'd4, 5'd4}, "equal fields");            // R5
        apply({'0, 5'd3, 5'd9}, "descending");              // R5
        w = '0; w[0 +: 5] = 5'd2; w[BW-1] = 1'b1;
        apply(w, "padding");                                // R6
        w = '0; w[7*5 +: 5] = 5'd20; w[6*5 +: 5] = 5'd10;
        apply(w, "int64 fp128");                            // R1 R3

        for (int n = 0; n < 60; n++) apply(gen_legal(), "rand legal");
        for (int n = 0; n < 30; n++) apply({24'd0, 8'($urandom), $urandom}, "rand any");
        for (int n = 0; n < 5; n++) begin
            w = gen_legal();
            w[NF*5 + ($urandom % (BW - NF*5))] = 1'b1;
            apply(w, "rand pad");                            // R6
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule